// File: doc/BRIEF.md
# Scatter-Gather DMA Channel

This block is one DMA channel that copies bytes between memory and I/O space under the control of descriptors it reads from memory itself. It is started with the address of the first descriptor. Each descriptor carries a control byte, a byte count, a source address, a destination address and, optionally, the address of the next descriptor. This allows one start to gather or scatter a frame across several buffers. The control byte sets how many bytes the channel fetches for each descriptor. Memory addresses take three bytes and I/O addresses take two. The link field is fetched only when the descriptor says it is present.

Data bytes move only when the peripheral requests them and the channel's programmed priority is not below the current CPU level. A retry request rewinds the channel to the initial descriptor, so a transmitter can resend a frame. In receive mode the channel writes a status byte over the first byte of the first descriptor when the chain ends. In transmit mode it redirects the final byte of a frame to a frame-end I/O address. The remaining count of the current descriptor is always visible, so software can size a buffer that the source ended early.

Top module: `sgdma_channel`

## Requirements
- R1: Descriptor bytes are read at fixed offsets from the descriptor base. The control byte is at offset 0. Control bit 0 = link present, bit 1 = source is I/O, bit 2 = destination is I/O, bit 3 = interrupt at completion, bit 4 = receive status. The link address is read from offsets 12..14 only when bit 0 is set. Offsets 9..11 are never read.
- R2: The count is at offsets 1..2, the source at 3..5 and the destination at 6..8, all little-endian. An I/O address field is fetched as 2 bytes from the low bytes of its slot, and a memory field as 3 bytes. Memory addresses step by one per byte moved, and I/O addresses stay fixed.
- R3: When a descriptor with bit 0 set finishes normally, the next descriptor is fetched from its link address. A descriptor without bit 0 ends the chain.
- R4: A retry pulse, in any state, clears done and irq. On the next cycle it restarts descriptor fetching at init_addr.
- R5: remain shows the bytes left in the current descriptor. If peri_end is high while the channel waits for a byte, the descriptor and the chain end with remain holding the untransferred count.
- R6: When the descriptor that ends the chain has bit 4 set, rx_status is written to memory address init_addr before done is raised.
- R7: While frame_tag_en is high, the last byte of a descriptor without a link is written to I/O address frame_end_addr, unless that descriptor's count was 1.
- R8: A data byte is read only while dreq is high and dma_prio >= cpu_level. Otherwise no data moves and remain holds.
- R9: A descriptor with count 0 moves no data bytes.
- R10: At the end of the chain, irq rises together with done when the last descriptor has bit 3 set. irq_vec always carries the channel's fixed vector (default 0x2C). irq stays high until start or retry.
- R11: After reset, busy, done, irq and bus_req are low. busy is high from start until done rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a chain at init_addr (ignored while busy) |
| retry | input | 1 | Rewind to init_addr and restart |
| init_addr | input | 24 | Address of the first descriptor |
| frame_tag_en | input | 1 | Transmit mode: redirect the final frame byte |
| frame_end_addr | input | 24 | I/O address that receives the final frame byte |
| rx_status | input | 8 | Status byte written at chain end in receive mode |
| dreq | input | 1 | Peripheral ready for one byte |
| peri_end | input | 1 | Peripheral ends the current buffer early |
| dma_prio | input | 2 | Programmed DMA priority |
| cpu_level | input | 2 | Current CPU operating level |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_io | output | 1 | 1 = I/O space, 0 = memory |
| bus_addr | output | 24 | Access address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Access completes in a cycle with bus_req and bus_ack high |
| busy | output | 1 | Channel active |
| done | output | 1 | Chain finished (sticky until start/retry) |
| irq | output | 1 | Interrupt request |
| irq_vec | output | 8 | Fixed interrupt vector of this channel |
| remain | output | 16 | Bytes left in the current descriptor |

## Verification
On every cycle the assertions check these properties. Descriptor offsets never fall in the padding gap. Each byte written drops remain by exactly one. A data read is entered only from a cycle where request and priority both allowed it. A zero count leaves the wait state straight for descriptor completion. A retry puts init_addr on the bus on the next cycle. irq never stands without done, and an idle channel makes no bus request. The bench scenarios are needed to show the rest. These are: the actual descriptor lengths (counted bus reads), link following, skipped source bytes for I/O fields, the data landing at the right addresses, the frame-end redirection and its one-byte exception, the status byte over the first descriptor, and the remaining count after an early end.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_FETCH = 3'd1,
    S_WAIT  = 3'd2,
    S_RD    = 3'd3,
    S_WR    = 3'd4,
    S_DDONE = 3'd5,
    S_STAT  = 3'd6,
    S_FIN   = 3'd7
  } chan_state_t;

  localparam int CB_LINK   = 0;
  localparam int CB_SRC_IO = 1;
  localparam int CB_DST_IO = 2;
  localparam int CB_IRQ    = 3;
  localparam int CB_RXSTAT = 4;

  localparam logic [3:0] OFF_CTRL   = 4'd0;
  localparam logic [3:0] OFF_CNT_LO = 4'd1;
  localparam logic [3:0] OFF_CNT_HI = 4'd2;
  localparam logic [3:0] OFF_SRC0   = 4'd3;
  localparam logic [3:0] OFF_SRC1   = 4'd4;
  localparam logic [3:0] OFF_SRC2   = 4'd5;
  localparam logic [3:0] OFF_DST0   = 4'd6;
  localparam logic [3:0] OFF_DST1   = 4'd7;
  localparam logic [3:0] OFF_DST2   = 4'd8;
  localparam logic [3:0] OFF_LNK0   = 4'd12;
  localparam logic [3:0] OFF_LNK1   = 4'd13;
  localparam logic [3:0] OFF_LNK2   = 4'd14;
endpackage

// File: rtl/sgdma_rst_sync.sv
module sgdma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sgdma_fetch_seq.sv
module sgdma_fetch_seq
  import sgdma_pkg::*;
(
  input  logic [3:0] off,
  input  logic [7:0] ctrl,
  output logic [3:0] nxt_off,
  output logic       last
);
  always_comb begin
    nxt_off = 4'(off + 4'd1);
    last    = 1'b0;
    case (off)
      OFF_SRC1: if (ctrl[CB_SRC_IO]) nxt_off = OFF_DST0;
      OFF_DST1: begin
        if (ctrl[CB_DST_IO]) begin
          if (ctrl[CB_LINK]) nxt_off = OFF_LNK0;
          else begin
            nxt_off = OFF_CTRL;
            last    = 1'b1;
          end
        end
      end
      OFF_DST2: begin
        if (ctrl[CB_LINK]) nxt_off = OFF_LNK0;
        else begin
          nxt_off = OFF_CTRL;
          last    = 1'b1;
        end
      end
      OFF_LNK2: begin
        nxt_off = OFF_CTRL;
        last    = 1'b1;
      end
      default: ;
    endcase
  end

  // R1: the padding gap and offset 15 are never visited
  always_comb begin
    a_r1_no_gap_offset: assert (!(off inside {4'd9, 4'd10, 4'd11, 4'd15}));
  end
endmodule

// File: rtl/sgdma_prio_gate.sv
module sgdma_prio_gate #(
  parameter int PW = 2
) (
  input  logic          dreq,
  input  logic [PW-1:0] dma_prio,
  input  logic [PW-1:0] cpu_level,
  output logic          go
);
  generate
    if (PW == 1) begin : g_flag
      assign go = dreq && (dma_prio[0] || !cpu_level[0]);
    end else begin : g_cmp
      assign go = dreq && (dma_prio >= cpu_level);
    end
  endgenerate
endmodule

// File: rtl/sgdma_desc_regs.sv
module sgdma_desc_regs
  import sgdma_pkg::*;
#(
  parameter int AW = 24,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [3:0]    cap_off,
  input  logic [7:0]    cap_byte,
  input  logic          step_en,
  output logic [7:0]    ctrl,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] first_cnt,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [AW-1:0] link
);
  localparam int HB = AW - 16;
  localparam int HC = CW - 8;

  logic [7:0]    ctrl_n;
  logic [CW-1:0] cnt_n, first_n;
  logic [AW-1:0] src_n, dst_n, link_n;
  logic          upd;

  always_comb begin
    ctrl_n  = ctrl;
    cnt_n   = cnt;
    first_n = first_cnt;
    src_n   = src;
    dst_n   = dst;
    link_n  = link;
    upd     = cap_en || step_en;
    if (cap_en) begin
      case (cap_off)
        OFF_CTRL:   ctrl_n = cap_byte;
        OFF_CNT_LO: begin
          cnt_n[7:0]   = cap_byte;
          first_n[7:0] = cap_byte;
        end
        OFF_CNT_HI: begin
          cnt_n[CW-1:8]   = cap_byte[HC-1:0];
          first_n[CW-1:8] = cap_byte[HC-1:0];
        end
        OFF_SRC0: src_n  = {{(AW-8){1'b0}}, cap_byte};
        OFF_SRC1: src_n[15:8] = cap_byte;
        OFF_SRC2: src_n[AW-1:16] = cap_byte[HB-1:0];
        OFF_DST0: dst_n  = {{(AW-8){1'b0}}, cap_byte};
        OFF_DST1: dst_n[15:8] = cap_byte;
        OFF_DST2: dst_n[AW-1:16] = cap_byte[HB-1:0];
        OFF_LNK0: link_n = {{(AW-8){1'b0}}, cap_byte};
        OFF_LNK1: link_n[15:8] = cap_byte;
        OFF_LNK2: link_n[AW-1:16] = cap_byte[HB-1:0];
        default: ;
      endcase
    end else if (step_en) begin
      cnt_n = cnt - 1'b1;
      if (!ctrl[CB_SRC_IO]) src_n = src + 1'b1;
      if (!ctrl[CB_DST_IO]) dst_n = dst + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      cnt       <= '0;
      first_cnt <= '0;
      src       <= '0;
      dst       <= '0;
      link      <= '0;
    end else if (upd) begin
      ctrl      <= ctrl_n;
      cnt       <= cnt_n;
      first_cnt <= first_n;
      src       <= src_n;
      dst       <= dst_n;
      link      <= link_n;
    end
  end

  // R5: every completed byte lowers the remaining count by one
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !cap_en) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/sgdma_channel.sv
module sgdma_channel
  import sgdma_pkg::*;
#(
  parameter int            AW         = 24,
  parameter int            CW         = 16,
  parameter int            PW         = 2,
  parameter int            VW         = 8,
  parameter logic [VW-1:0] IRQ_VECTOR = 8'h2C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          retry,
  input  logic [AW-1:0] init_addr,
  input  logic          frame_tag_en,
  input  logic [AW-1:0] frame_end_addr,
  input  logic [7:0]    rx_status,
  input  logic          dreq,
  input  logic          peri_end,
  input  logic [PW-1:0] dma_prio,
  input  logic [PW-1:0] cpu_level,
  output logic          bus_req,
  output logic          bus_we,
  output logic          bus_io,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  input  logic [7:0]    bus_rdata,
  input  logic          bus_ack,
  output logic          busy,
  output logic          done,
  output logic          irq,
  output logic [VW-1:0] irq_vec,
  output logic [CW-1:0] remain
);
  logic rst_i_n;

  sgdma_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  chan_state_t   state, state_n;
  logic [3:0]    off, off_n;
  logic [AW-1:0] ptr, ptr_n;
  logic [7:0]    data_q, data_n;
  logic          early_q, early_n;
  logic          done_q, done_n;
  logic          irq_q, irq_n;

  logic [7:0]    ctrl;
  logic [CW-1:0] cnt, first_cnt;
  logic [AW-1:0] src, dst, link;
  logic [3:0]    seq_nxt;
  logic          seq_last;
  logic          go;
  logic          cap_en, step_en, tag_last;

  sgdma_fetch_seq u_seq (
    .off(off), .ctrl(ctrl), .nxt_off(seq_nxt), .last(seq_last)
  );

  sgdma_prio_gate #(.PW(PW)) u_gate (
    .dreq(dreq), .dma_prio(dma_prio), .cpu_level(cpu_level), .go(go)
  );

  assign cap_en  = (state == S_FETCH) && bus_ack;
  assign step_en = (state == S_WR) && bus_ack;

  sgdma_desc_regs #(.AW(AW), .CW(CW)) u_desc (
    .clk(clk), .rst_n(rst_i_n),
    .cap_en(cap_en), .cap_off(off), .cap_byte(bus_rdata),
    .step_en(step_en),
    .ctrl(ctrl), .cnt(cnt), .first_cnt(first_cnt),
    .src(src), .dst(dst), .link(link)
  );

  // final byte of a frame goes to the frame-end address, except one-byte buffers
  assign tag_last = frame_tag_en && !ctrl[CB_LINK] &&
                    (cnt == CW'(1)) && (first_cnt != CW'(1));

  always_comb begin
    state_n = state;
    off_n   = off;
    ptr_n   = ptr;
    data_n  = data_q;
    early_n = early_q;
    done_n  = done_q;
    irq_n   = irq_q;
    case (state)
      S_IDLE: begin
        if (start) begin
          state_n = S_FETCH;
          ptr_n   = init_addr;
          off_n   = OFF_CTRL;
          early_n = 1'b0;
          done_n  = 1'b0;
          irq_n   = 1'b0;
        end
      end
      S_FETCH: begin
        if (bus_ack) begin
          off_n = seq_nxt;
          if (seq_last) state_n = S_WAIT;
        end
      end
      S_WAIT: begin
        if (cnt == '0) state_n = S_DDONE;
        else if (peri_end) begin
          early_n = 1'b1;
          state_n = S_DDONE;
        end else if (go) state_n = S_RD;
      end
      S_RD: begin
        if (bus_ack) begin
          data_n  = bus_rdata;
          state_n = S_WR;
        end
      end
      S_WR: begin
        if (bus_ack) state_n = S_WAIT;
      end
      S_DDONE: begin
        if (ctrl[CB_LINK] && !early_q) begin
          state_n = S_FETCH;
          ptr_n   = link;
          off_n   = OFF_CTRL;
        end else if (ctrl[CB_RXSTAT]) state_n = S_STAT;
        else state_n = S_FIN;
      end
      S_STAT: begin
        if (bus_ack) state_n = S_FIN;
      end
      S_FIN: begin
        state_n = S_IDLE;
        done_n  = 1'b1;
        irq_n   = ctrl[CB_IRQ];
      end
      default: state_n = S_IDLE;
    endcase
    if (retry) begin
      state_n = S_FETCH;
      ptr_n   = init_addr;
      off_n   = OFF_CTRL;
      early_n = 1'b0;
      done_n  = 1'b0;
      irq_n   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state   <= S_IDLE;
      off     <= '0;
      ptr     <= '0;
      data_q  <= '0;
      early_q <= 1'b0;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state   <= state_n;
      off     <= off_n;
      ptr     <= ptr_n;
      data_q  <= data_n;
      early_q <= early_n;
      done_q  <= done_n;
      irq_q   <= irq_n;
    end
  end

  always_comb begin
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_io    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    case (state)
      S_FETCH: begin
        bus_req  = 1'b1;
        bus_addr = ptr + AW'(off);
      end
      S_RD: begin
        bus_req  = 1'b1;
        bus_io   = ctrl[CB_SRC_IO];
        bus_addr = src;
      end
      S_WR: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_io    = tag_last ? 1'b1 : ctrl[CB_DST_IO];
        bus_addr  = tag_last ? frame_end_addr : dst;
        bus_wdata = data_q;
      end
      S_STAT: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = init_addr;
        bus_wdata = rx_status;
      end
      default: ;
    endcase
  end

  assign busy    = (state != S_IDLE);
  assign done    = done_q;
  assign irq     = irq_q;
  assign irq_vec = IRQ_VECTOR;
  assign remain  = cnt;

  // R8: a data read is only entered from a cycle where the gate was open
  a_r8_read_gated: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state == S_RD && $past(state) == S_WAIT) |-> $past(go));

  // R9: an empty descriptor goes straight to completion
  a_r9_zero_skips: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state == S_WAIT && cnt == '0 && !retry) |=> (state == S_DDONE));

  // R4: retry restarts the fetch at the initial descriptor address
  a_r4_retry_rewinds: assert property (@(posedge clk) disable iff (!rst_i_n)
    retry |=> (bus_req && !bus_we && bus_addr == $past(init_addr)));

  // R10: an interrupt is only raised for a finished chain
  a_r10_irq_with_done: assert property (@(posedge clk) disable iff (!rst_i_n)
    irq |-> done);

  // R11: an idle channel leaves the bus alone
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_i_n)
    !busy |-> !bus_req);
endmodule

// File: tb/sgdma_channel_tb.sv
module sgdma_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, retry, frame_tag_en, dreq, peri_end;
  logic [23:0] init_addr, frame_end_addr;
  logic [7:0]  rx_status;
  logic [1:0]  dma_prio, cpu_level;
  logic        bus_req, bus_we, bus_io, bus_ack;
  logic [23:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        busy, done, irq;
  logic [7:0]  irq_vec;
  logic [15:0] remain;

  logic [7:0] mem  [0:1023];
  logic [7:0] io_m [0:255];
  int   nchk = 0, nerr = 0;
  int   n_rd = 0, n_wr = 0, n_tag = 0;
  logic clr_stats = 1'b0;
  logic stall_en = 1'b0;
  logic cyc = 1'b0;

  always #5 clk = ~clk;

  sgdma_channel dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .retry(retry),
    .init_addr(init_addr), .frame_tag_en(frame_tag_en),
    .frame_end_addr(frame_end_addr), .rx_status(rx_status),
    .dreq(dreq), .peri_end(peri_end), .dma_prio(dma_prio),
    .cpu_level(cpu_level), .bus_req(bus_req), .bus_we(bus_we),
    .bus_io(bus_io), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .busy(busy),
    .done(done), .irq(irq), .irq_vec(irq_vec), .remain(remain)
  );

  assign bus_ack   = !(stall_en && cyc);
  assign bus_rdata = bus_io ? io_m[bus_addr[7:0]] : mem[bus_addr[9:0]];

  always @(posedge clk) begin
    cyc <= ~cyc;
    if (clr_stats) begin
      n_rd <= 0; n_wr <= 0; n_tag <= 0;
    end else if (bus_req && bus_ack) begin
      if (bus_we) begin
        n_wr <= n_wr + 1;
        if (bus_io) begin
          io_m[bus_addr[7:0]] <= bus_wdata;
          if (bus_addr == frame_end_addr) n_tag <= n_tag + 1;
        end else mem[bus_addr[9:0]] <= bus_wdata;
      end else n_rd <= n_rd + 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic put_desc(int base, int ctrl, int cnt, int src, int dst, int lnk);
    mem[base]    = 8'(ctrl);
    mem[base+1]  = 8'(cnt);      mem[base+2]  = 8'(cnt >> 8);
    mem[base+3]  = 8'(src);      mem[base+4]  = 8'(src >> 8);
    mem[base+5]  = 8'(src >> 16);
    mem[base+6]  = 8'(dst);      mem[base+7]  = 8'(dst >> 8);
    mem[base+8]  = 8'(dst >> 16);
    mem[base+9]  = 8'h00; mem[base+10] = 8'h00; mem[base+11] = 8'h00;
    mem[base+12] = 8'(lnk);      mem[base+13] = 8'(lnk >> 8);
    mem[base+14] = 8'(lnk >> 16);
  endtask

  task automatic prep();
    @(negedge clk);
    clr_stats = 1'b1;
    @(negedge clk);
    clr_stats = 1'b0;
    for (int i = 0; i < 8; i++) mem[12'h200 + i] = 8'(8'h11 + i);
  endtask

  task automatic kick(int base);
    @(negedge clk);
    init_addr = 24'(base);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000; i++) begin
      if (done) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R11 busy after reset", int'(busy), 0);
    chk("R11 done after reset", int'(done), 0);
    chk("R11 irq after reset", int'(irq), 0);
    chk("R11 bus_req after reset", int'(bus_req), 0);
  endtask

  task automatic t_single();
    prep();
    put_desc(12'h100, 8'h08, 4, 12'h200, 12'h300, 0);
    kick(12'h100);
    chk("R11 busy while running", int'(busy), 1);
    wait_done();
    for (int i = 0; i < 4; i++) chk("R2 memory copy", int'(mem[12'h300 + i]), 8'h11 + i);
    chk("R1 12-byte form reads", n_rd, 9 + 4);
    chk("R10 irq set", int'(irq), 1);
    chk("R10 vector", int'(irq_vec), 8'h2C);
    chk("R5 remain zero", int'(remain), 0);
    chk("R11 idle after done", int'(busy), 0);
  endtask

  task automatic t_chain();
    prep();
    stall_en = 1'b1;
    put_desc(12'h100, 8'h01, 3, 12'h200, 12'h310, 12'h140);
    put_desc(12'h140, 8'h02, 2, 8'h55, 12'h320, 0);
    mem[12'h145] = 8'hEE;
    io_m[8'h55] = 8'h7A;
    kick(12'h100);
    wait_done();
    stall_en = 1'b0;
    for (int i = 0; i < 3; i++) chk("R3 first buffer", int'(mem[12'h310 + i]), 8'h11 + i);
    chk("R2 fixed io source byte0", int'(mem[12'h320]), 8'h7A);
    chk("R2 fixed io source byte1", int'(mem[12'h321]), 8'h7A);
    chk("R1 link and io field read count", n_rd, 12 + 3 + 8 + 2);
    chk("R10 no irq without bit3", int'(irq), 0);
  endtask

  task automatic t_zero();
    prep();
    put_desc(12'h100, 8'h08, 0, 12'h200, 12'h300, 0);
    kick(12'h100);
    wait_done();
    chk("R9 no writes", n_wr, 0);
    chk("R9 only descriptor reads", n_rd, 9);
    chk("R9 done", int'(done), 1);
  endtask

  task automatic t_gate();
    prep();
    mem[12'h330] = 8'h00; mem[12'h331] = 8'h00;
    put_desc(12'h100, 8'h00, 2, 12'h200, 12'h330, 0);
    dma_prio = 2'd0; cpu_level = 2'd1;
    kick(12'h100);
    repeat (40) @(negedge clk);
    chk("R8 blocked by cpu level: writes", n_wr, 0);
    chk("R8 blocked: remain holds", int'(remain), 2);
    chk("R8 blocked: busy", int'(busy), 1);
    dma_prio = 2'd2; dreq = 1'b0;
    repeat (20) @(negedge clk);
    chk("R8 blocked by dreq: writes", n_wr, 0);
    dreq = 1'b1;
    wait_done();
    dma_prio = 2'd3; cpu_level = 2'd0;
    chk("R8 resumes byte0", int'(mem[12'h330]), 8'h11);
    chk("R8 resumes byte1", int'(mem[12'h331]), 8'h12);
  endtask

  task automatic t_tag();
    prep();
    frame_tag_en = 1'b1;
    frame_end_addr = 24'h0000F0;
    io_m[8'hF0] = 8'h00; io_m[8'h40] = 8'h00;
    put_desc(12'h100, 8'h04, 3, 12'h200, 8'h40, 0);
    kick(12'h100);
    wait_done();
    chk("R7 one tagged write", n_tag, 1);
    chk("R7 last byte at frame end", int'(io_m[8'hF0]), 8'h13);
    chk("R7 earlier byte at fixed io dst", int'(io_m[8'h40]), 8'h12);
    chk("R1 io destination field read count", n_rd, 8 + 3);
    prep();
    io_m[8'hF0] = 8'h00;
    put_desc(12'h100, 8'h04, 1, 12'h200, 8'h40, 0);
    kick(12'h100);
    wait_done();
    chk("R7 single byte not tagged", n_tag, 0);
    chk("R7 single byte at dst", int'(io_m[8'h40]), 8'h11);
    frame_tag_en = 1'b0;
  endtask

  task automatic t_rxstat();
    prep();
    rx_status = 8'hA5;
    put_desc(12'h100, 8'h10, 2, 12'h200, 12'h340, 0);
    kick(12'h100);
    wait_done();
    chk("R6 status over first byte", int'(mem[12'h100]), 8'hA5);
    chk("R6 data plus status writes", n_wr, 3);
  endtask

  task automatic t_early();
    prep();
    put_desc(12'h100, 8'h00, 5, 12'h200, 12'h350, 0);
    kick(12'h100);
    for (int i = 0; i < 500; i++) begin
      if (n_wr == 2) break;
      @(negedge clk);
    end
    dreq = 1'b0; peri_end = 1'b1;
    wait_done();
    peri_end = 1'b0; dreq = 1'b1;
    chk("R5 remain after early end", int'(remain), 3);
    chk("R5 writes before end", n_wr, 2);
    chk("R5 chain done", int'(done), 1);
  endtask

  task automatic t_retry();
    prep();
    put_desc(12'h100, 8'h08, 4, 12'h200, 12'h360, 0);
    kick(12'h100);
    for (int i = 0; i < 500; i++) begin
      if (n_wr == 1) break;
      @(negedge clk);
    end
    retry = 1'b1;
    @(negedge clk);
    retry = 1'b0;
    chk("R4 fetch restarts at init", int'(bus_addr), 12'h100);
    chk("R4 restart is a read", int'(bus_req && !bus_we), 1);
    chk("R4 done cleared", int'(done), 0);
    wait_done();
    chk("R4 total writes", n_wr, 5);
    for (int i = 0; i < 4; i++) chk("R4 data after retry", int'(mem[12'h360 + i]), 8'h11 + i);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; retry = 1'b0; frame_tag_en = 1'b0;
    dreq = 1'b1; peri_end = 1'b0; init_addr = '0;
    frame_end_addr = 24'h0000F0; rx_status = 8'h00;
    dma_prio = 2'd3; cpu_level = 2'd0;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    for (int i = 0; i < 256; i++) io_m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_chain();
    t_zero();
    t_gate();
    t_tag();
    t_rxstat();
    t_early();
    t_retry();
    summary();
    $finish;
  end
endmodule